// File: doc/BRIEF.md
# Inactivity-Timed Transceiver Power Controller

This block decides when the supply generator and line drivers of a serial line interface may be switched off. It watches three transmit-data and five receive-data inputs, which arrive already digitized. Each input passes through a two-stage synchronizer, and a change of level on any of them counts as activity. When no activity has been seen for a programmable number of ticks, the block enters an automatic power-down. In that state the charge pump and the transmitter outputs are off, but the standard receivers stay enabled so that incoming traffic can still be read. Any later input change brings the interface back up.

Two control pins override the timer. An active-low force-off pin shuts everything down except the monitor receiver. An active-high force-on pin keeps the interface up without limit. Power-down is sticky. Once the interface is down, for either reason, it stays down until an input changes level or force-on is driven high. Releasing force-off alone does not wake it. After the pump is re-enabled, the transmitter enable waits for a programmable number of ticks while the supplies settle. Time is counted only on a single-cycle `tick` input, so a bench can shrink the nominal 30 s idle period to a few dozen cycles.

Top module: `xcvr_pwr_ctl`

## Requirements
- R1: A synchronous reset leaves the block powered up: pump_en, tx_oe, rx_oe, mon_oe and pwr_ready all read 1, and the idle count is cleared.
- R2: Every data input (tx_in, rx_in) and both control pins pass through two flops. A level change on any data input counts as activity and restarts the idle count, so inputs that toggle more often than the idle period never cause a power-down.
- R3: With force_off_n=1 and force_on=0, IDLE_TICKS ticks with no activity cause pump_en and tx_oe to drop while rx_oe stays 1.
- R4: A level change on any data input during automatic power-down sets pump_en to 1 after the third rising clock edge that follows the change.
- R5: When force_off_n is low, pump_en, tx_oe and rx_oe are 0, whatever force_on and the data inputs do. This takes effect two edges after the pin falls.
- R6: After any power-down, releasing force_off_n while force_on is low leaves the outputs down until a data input changes level.
- R7: While force_on=1 and force_off_n=1, no automatic power-down occurs. Raising force_on wakes an interface that is down.
- R8: tx_oe and pwr_ready rise only after WAKE_TICKS ticks have passed with pump_en high. They fall in the same cycle as pump_en.
- R9: mon_oe is 1 in every mode, including forced power-down.
- R10: If activity arrives in the same cycle as the tick that would end the idle period, the activity wins: no power-down occurs and the count restarts.
- R11: Data-input changes made while force_off_n is low are ignored and do not wake the interface once force_off_n is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle time-base strobe |
| tx_in | input | N_TX | Digitized transmit-data inputs |
| rx_in | input | N_RX | Digitized receive-data inputs |
| force_off_n | input | 1 | Forced shutdown, active low, dominant |
| force_on | input | 1 | Keeps the interface powered, active high |
| pump_en | output | 1 | Charge-pump enable |
| tx_oe | output | 1 | Transmitter output enable |
| rx_oe | output | 1 | Standard receiver output enable |
| mon_oe | output | 1 | Monitor receiver enable |
| pwr_ready | output | 1 | Supplies settled, transmitters live |

## Verification
Two pairs of events can land in the same cycle. In the first, the activity strobe meets the tick that would end the idle period. In the second, an input change occurs while force-off is low. The bench provokes the first by sweeping the position of a restarting toggle across several cycles around the expiry point. It provokes the second by toggling inputs during force-off and then releasing it. A cycle-accurate behavioural model in the bench judges every cycle, and directed checks confirm that the interface stays down after the force-off release.

// File: rtl/xcvr_pwr_ctl.sv
`timescale 1ns/1ps
module xcvr_pwr_ctl #(
  parameter int N_TX       = 3,
  parameter int N_RX       = 5,
  parameter int IDLE_TICKS = 3000000,
  parameter int WAKE_TICKS = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic [N_TX-1:0] tx_in,
  input  logic [N_RX-1:0] rx_in,
  input  logic            force_off_n,
  input  logic            force_on,
  output logic            pump_en,
  output logic            tx_oe,
  output logic            rx_oe,
  output logic            mon_oe,
  output logic            pwr_ready
);
  localparam int NIN = N_TX + N_RX;
  localparam int IW  = $clog2(IDLE_TICKS + 1);
  localparam int WW  = $clog2(WAKE_TICKS + 1);

  logic [NIN-1:0] d1, d2, d3;
  logic [1:0]     off_sy, on_sy;
  logic           timed_out, ready;
  logic [IW-1:0]  idle_cnt;
  logic [WW-1:0]  wake_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      d1     <= '0;
      d2     <= '0;
      d3     <= '0;
      off_sy <= 2'b11;
      on_sy  <= 2'b00;
    end else begin
      d1     <= {tx_in, rx_in};
      d2     <= d1;
      d3     <= d2;
      off_sy <= {off_sy[0], force_off_n};
      on_sy  <= {on_sy[0], force_on};
    end
  end

  wire activity = |(d2 ^ d3);
  wire off_ok   = off_sy[1];
  wire on_req   = on_sy[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      timed_out <= 1'b0;
      idle_cnt  <= '0;
    end else if (!off_ok) begin
      timed_out <= 1'b1;
      idle_cnt  <= '0;
    end else if (on_req || activity) begin
      timed_out <= 1'b0;
      idle_cnt  <= '0;
    end else if (tick && !timed_out) begin
      if (idle_cnt == IW'(IDLE_TICKS - 1)) begin
        timed_out <= 1'b1;
        idle_cnt  <= '0;
      end else begin
        idle_cnt <= idle_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready    <= 1'b1;
      wake_cnt <= '0;
    end else if (!pump_en) begin
      ready    <= 1'b0;
      wake_cnt <= '0;
    end else if (!ready && tick) begin
      if (wake_cnt == WW'(WAKE_TICKS - 1)) ready <= 1'b1;
      else wake_cnt <= wake_cnt + 1'b1;
    end
  end

  assign pump_en   = off_ok & ~timed_out;
  assign rx_oe     = off_ok;
  assign tx_oe     = pump_en & ready;
  assign pwr_ready = tx_oe;
  assign mon_oe    = 1'b1;
endmodule

// File: rtl/xcvr_pwr_ctl_chk.sv
`timescale 1ns/1ps
module xcvr_pwr_ctl_chk (
  input logic clk,
  input logic rst,
  input logic force_off_n,
  input logic force_on,
  input logic pump_en,
  input logic tx_oe,
  input logic rx_oe
);
  p_tx_needs_pump_r8: assert property (@(posedge clk) disable iff (rst)
    tx_oe |-> pump_en);

  p_tx_rise_after_pump_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_oe) |-> $past(pump_en));

  p_pump_implies_rx_r5: assert property (@(posedge clk) disable iff (rst)
    pump_en |-> rx_oe);

  p_force_off_r5: assert property (@(posedge clk) disable iff (rst)
    (!force_off_n && $past(!force_off_n)) |=> (!rx_oe && !pump_en && !tx_oe));

  p_force_on_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (force_on && force_off_n && $past(force_on) && $past(force_off_n) &&
     $past(force_on, 2) && $past(force_off_n, 2)) |=> pump_en);
endmodule

bind xcvr_pwr_ctl xcvr_pwr_ctl_chk u_chk (
  .clk(clk), .rst(rst), .force_off_n(force_off_n), .force_on(force_on),
  .pump_en(pump_en), .tx_oe(tx_oe), .rx_oe(rx_oe)
);

// File: tb/test_xcvr_pwr_ctl.sv
`timescale 1ns/1ps
module test_xcvr_pwr_ctl;
  localparam int IDLE = 20;
  localparam int WAKE = 4;
  localparam int TDIV = 3;

  logic clk = 0, rst = 1, tick = 0;
  logic [2:0] tx = '0;
  logic [4:0] rx = '0;
  logic foff_n = 1, fon = 0;
  logic pump_en, tx_oe, rx_oe, mon_oe, pwr_ready;

  xcvr_pwr_ctl #(.N_TX(3), .N_RX(5), .IDLE_TICKS(IDLE), .WAKE_TICKS(WAKE)) i_xcvr_pwr_ctl (
    .clk(clk), .rst(rst), .tick(tick), .tx_in(tx), .rx_in(rx),
    .force_off_n(foff_n), .force_on(fon),
    .pump_en(pump_en), .tx_oe(tx_oe), .rx_oe(rx_oe), .mon_oe(mon_oe), .pwr_ready(pwr_ready));

  always #2.5 clk = ~clk;

  int errs = 0, checks = 0, tc = 0;
  string tag = "R1";
  bit done = 0;

  task automatic chk(string t, string what, logic a, logic e);
    checks++;
    if (a !== e) begin
      errs++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", t, what, a, e, $time);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    tick <= (tc == 0);
    tc = (tc == TDIV - 1) ? 0 : tc + 1;
  end

  // behavioural reference: pin history {force_on, force_off_n, tx, rx}
  logic [9:0] h1, h2, h3;
  int  m_idle = 0, m_wake = 0;
  bit  m_to = 0, m_rdy = 1;
  bit  e_pump = 1, e_tx = 1, e_rx = 1;

  always @(posedge clk) begin
    bit act, pump_old;
    if (rst) begin
      h1 = {1'b0, 1'b1, 8'h00}; h2 = h1; h3 = h1;
      m_to = 0; m_idle = 0; m_wake = 0; m_rdy = 1;
    end else begin
      act      = (h2[7:0] != h3[7:0]);
      pump_old = h2[8] && !m_to;
      if (!pump_old) begin m_rdy = 0; m_wake = 0; end
      else if (!m_rdy && tick) begin
        if (m_wake == WAKE - 1) m_rdy = 1; else m_wake++;
      end
      if (!h2[8]) begin m_to = 1; m_idle = 0; end
      else if (h2[9] || act) begin m_to = 0; m_idle = 0; end
      else if (tick && !m_to) begin
        if (m_idle == IDLE - 1) begin m_to = 1; m_idle = 0; end
        else m_idle++;
      end
      h3 = h2; h2 = h1; h1 = {fon, foff_n, tx, rx};
    end
    e_pump = h2[8] && !m_to;
    e_rx   = h2[8];
    e_tx   = m_rdy && e_pump;
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(tag, "pump_en", pump_en, e_pump);
      chk(tag, "tx_oe", tx_oe, e_tx);
      chk(tag, "rx_oe", rx_oe, e_rx);
      chk("R8", "pwr_ready", pwr_ready, e_tx);
      chk("R9", "mon_oe", mon_oe, 1'b1);
    end
  end

  initial begin
    wait_n(4);
    rst = 0;
    wait_n(1);
    tag = "R1";
    chk("R1", "reset pump_en", pump_en, 1'b1);
    chk("R1", "reset tx_oe", tx_oe, 1'b1);
    chk("R1", "reset rx_oe", rx_oe, 1'b1);
    chk("R1", "reset pwr_ready", pwr_ready, 1'b1);

    tag = "R2";
    for (int i = 0; i < 10; i++) begin
      tx[i % 3] = ~tx[i % 3];
      wait_n(IDLE * TDIV / 2);
    end
    chk("R2", "still up with activity", pump_en, 1'b1);

    tag = "R3";
    wait_n(IDLE * TDIV + 20);
    chk("R3", "idle pump_en", pump_en, 1'b0);
    chk("R3", "idle tx_oe", tx_oe, 1'b0);
    chk("R3", "idle rx_oe", rx_oe, 1'b1);

    tag = "R4";
    rx[3] = 1;
    wait_n(2);
    chk("R4", "pump before third edge", pump_en, 1'b0);
    wait_n(1);
    chk("R4", "pump after third edge", pump_en, 1'b1);
    chk("R8", "tx_oe waits for settle", tx_oe, 1'b0);
    wait_n(WAKE * TDIV + 6);
    chk("R8", "tx_oe after settle", tx_oe, 1'b1);

    tag = "R5";
    fon = 1; foff_n = 0;
    wait_n(1);
    tx[0] = ~tx[0];
    wait_n(3);
    chk("R5", "forced pump_en", pump_en, 1'b0);
    chk("R5", "forced rx_oe", rx_oe, 1'b0);
    chk("R5", "forced tx_oe", tx_oe, 1'b0);
    chk("R9", "forced mon_oe", mon_oe, 1'b1);

    tag = "R11";
    fon = 0;
    rx[0] = 1; wait_n(3); rx[0] = 0; wait_n(3);
    foff_n = 1;
    wait_n(10);
    chk("R11", "no wake from edges during force-off", pump_en, 1'b0);
    chk("R6", "sticky after release rx_oe", rx_oe, 1'b1);

    tag = "R6";
    tx[2] = ~tx[2];
    wait_n(4);
    chk("R6", "wake on edge after release", pump_en, 1'b1);

    tag = "R7";
    fon = 1;
    wait_n(IDLE * TDIV * 3);
    chk("R7", "force_on holds up", pump_en, 1'b1);
    fon = 0;
    wait_n(IDLE * TDIV + 20);
    chk("R7", "down after force_on low", pump_en, 1'b0);
    fon = 1;
    wait_n(4);
    chk("R7", "force_on rise wakes", pump_en, 1'b1);
    fon = 0;
    wait_n(10);

    tag = "R10";
    for (int off = 0; off < 10; off++) begin
      tx[1] = ~tx[1];
      wait_n(IDLE * TDIV - 6 + off);
      tx[1] = ~tx[1];
      wait_n(IDLE * TDIV + 20);
    end
    tx[1] = ~tx[1];
    wait_n(IDLE * TDIV - 10);
    tx[1] = ~tx[1];
    wait_n(IDLE * TDIV - 10);
    chk("R10", "restarted count keeps up", pump_en, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule